// File: doc/BRIEF.md
# Nibble Serial Register Access Engine

This block is a bit-level master for a three-wire serial link to a small clock chip. It drives a serial clock and one bidirectional data pin, given as a data output, an output enable and a data input. The chip-enable wire stays with the caller. A single request carries a direction, a 4-bit register address and, for writes, a 4-bit data nibble. The engine then sends the whole transaction as one frame of sixteen bit slots and reports the result with a one-cycle done pulse.

A frame opens with a 4-bit control nibble. Its leading slot is a don't-care sent as one. The remaining three slots are flags for direction, address phase and data phase. The register address follows, most significant bit first. A read releases the data pin after the last address bit, lets four dummy slots go by, and shifts the next four input bits into the result. A write keeps driving and sends a second control nibble that marks the data phase, then the data nibble. Each bit slot spends a low half and a high half of the serial clock. The length of each half comes from a divider setting that is latched at the start of the transaction.

The caller raises chip-enable, issues one or more requests, each after the previous done, and drops chip-enable afterwards. Retries, polling of a busy bit and the meaning of the registers belong to the caller.

Top module: `nib_serial_master`

## Requirements
- R1: After reset the serial clock is low, the output enable is high, and busy and done are both low.
- R2: A read sends, on the data output at the rising serial clock edges, the control nibble 1,1,1,0 and then address bits A3, A2, A1, A0, in that order.
- R3: During a read the output enable is high for the first eight bit slots and low for the last eight. During a write it stays high for all sixteen slots.
- R4: A read discards the input bits sampled in slots 8 to 11. It captures the bits sampled in slots 12 to 15 as rdata[3] down to rdata[0], so the first captured bit is the most significant.
- R5: A write sends 1,0,1,0, then A3 to A0, then 1,0,0,1, then D3 to D0, one bit per rising serial clock edge.
- R6: With a divider setting H, each half of every bit slot lasts H+1 clock cycles. The first serial clock rise comes H+1 cycles after the accepting edge. Done comes 32*(H+1) cycles after it.
- R7: A start request is accepted only while busy is low. A request made while busy changes neither the ongoing frame nor the result, and no further frame follows it. Busy stays high from the accepting edge until done.
- R8: Done is high for exactly one cycle. In that cycle rdata holds the captured nibble for a read and zero for a write.
- R9: When done is high, the serial clock is low, the output enable is high and busy is low. The serial clock stays low while idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_start | input | 1 | Request a transaction (taken only while idle) |
| req_read | input | 1 | 1 = read, 0 = write |
| req_addr | input | 4 | Register address |
| req_wdata | input | 4 | Write data nibble |
| cfg_half | input | DIV_W | Serial clock half-period minus one, in clock cycles |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 4 | Read result, valid with done |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Data pin output enable |
| sdi | input | 1 | Serial data in |

## Verification
Every result is due a fixed number of cycles after the accepting edge: the first serial clock rise after H+1 cycles, and done with rdata after 32*(H+1) cycles. The bench drives each request at a falling clock edge. It counts rising clock edges from the accepting one and samples only at the following falling edge, then compares both counts with these figures. Bits on the data output and the output enable are recorded at each serial clock rise. The input bit for each slot is set from a pattern indexed by the number of rises so far, so it is stable across the low half in which the design samples it. The pattern uses dummy bits that differ from the data bits, so a wrong capture window shows up as a wrong nibble.

// File: rtl/nsm_pkg.sv
package nsm_pkg;
   localparam int NIB        = 4;
   localparam int FRAME_BITS = 4 * NIB;
   localparam int IDX_W      = $clog2(FRAME_BITS);

   localparam logic [NIB-1:0] CTL_RD_ADDR = 4'b1110;
   localparam logic [NIB-1:0] CTL_WR_ADDR = 4'b1010;
   localparam logic [NIB-1:0] CTL_WR_DATA = 4'b1001;

   typedef enum logic {OP_WRITE = 1'b0, OP_READ = 1'b1} op_e;

   // Whole outgoing frame, first bit at the MSB; read slots after the address are padding
   function automatic logic [FRAME_BITS-1:0] build_frame(input logic rd,
                                                         input logic [NIB-1:0] addr,
                                                         input logic [NIB-1:0] wd);
      if (rd)
         return {CTL_RD_ADDR, addr, {(2*NIB){1'b0}}};
      return {CTL_WR_ADDR, addr, CTL_WR_DATA, wd};
   endfunction
endpackage

// File: rtl/nsm_tick.sv
module nsm_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             phase_end
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!run || cnt == half)
         cnt <= '0;
      else
         cnt <= cnt + 1'b1;
   end

   assign phase_end = run && (cnt == half);
endmodule

// File: rtl/nsm_ctrl.sv
module nsm_ctrl
   import nsm_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             req_read,
   input  logic             phase_end,
   output logic             busy,
   output logic             sclk,
   output logic             is_read,
   output logic [IDX_W-1:0] bit_idx,
   output logic             sample,
   output logic             advance,
   output logic             done,
   output logic             oe
);
   localparam logic [IDX_W-1:0] LAST    = IDX_W'(FRAME_BITS - 1);
   localparam logic [IDX_W-1:0] TURN_AT = IDX_W'(2 * NIB);

   logic last_fall;

   assign sample    = busy && phase_end && !sclk;
   assign last_fall = busy && phase_end && sclk && (bit_idx == LAST);
   assign advance   = busy && phase_end && sclk && (bit_idx != LAST);
   assign oe        = !(busy && is_read && (bit_idx >= TURN_AT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy    <= 1'b0;
         sclk    <= 1'b0;
         is_read <= 1'b0;
         bit_idx <= '0;
         done    <= 1'b0;
      end else begin
         done <= last_fall;
         if (accept) begin
            busy    <= 1'b1;
            sclk    <= 1'b0;
            is_read <= (op_e'(req_read) == OP_READ);
            bit_idx <= '0;
         end else if (sample) begin
            sclk <= 1'b1;
         end else if (last_fall) begin
            busy <= 1'b0;
            sclk <= 1'b0;
         end else if (advance) begin
            sclk    <= 1'b0;
            bit_idx <= bit_idx + 1'b1;
         end
      end
   end
endmodule

// File: rtl/nsm_shifter.sv
module nsm_shifter
   import nsm_pkg::*;
#(
   parameter bit HOLD_RDATA = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             req_read,
   input  logic [NIB-1:0]   req_addr,
   input  logic [NIB-1:0]   req_wdata,
   input  logic             advance,
   input  logic             sample,
   input  logic             is_read,
   input  logic [IDX_W-1:0] bit_idx,
   input  logic             done,
   input  logic             sdi,
   output logic             sdo,
   output logic [NIB-1:0]   rdata
);
   localparam logic [IDX_W-1:0] CAP_AT = IDX_W'(3 * NIB);

   logic [FRAME_BITS-1:0] frame;
   logic [NIB-1:0]        cap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frame <= '0;
         cap   <= '0;
      end else begin
         if (accept)
            frame <= build_frame(req_read, req_addr, req_wdata);
         else if (advance)
            frame <= {frame[FRAME_BITS-2:0], 1'b0};

         if (accept)
            cap <= '0;
         else if (sample && is_read && bit_idx >= CAP_AT)
            cap <= {cap[NIB-2:0], sdi};
      end
   end

   assign sdo = frame[FRAME_BITS-1];

   generate
      if (HOLD_RDATA) begin : g_hold
         assign rdata = cap;
      end else begin : g_gate
         assign rdata = (done && is_read) ? cap : '0;
      end
   endgenerate
endmodule

// File: rtl/nib_serial_master.sv
module nib_serial_master
   import nsm_pkg::*;
#(
   parameter int DIV_W      = 8,
   parameter bit HOLD_RDATA = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_start,
   input  logic             req_read,
   input  logic [3:0]       req_addr,
   input  logic [3:0]       req_wdata,
   input  logic [DIV_W-1:0] cfg_half,
   output logic             busy,
   output logic             done,
   output logic [3:0]       rdata,
   output logic             sclk,
   output logic             sdo,
   output logic             sdo_oe,
   input  logic             sdi
);
   generate
      if (DIV_W < 1 || DIV_W > 16) begin : g_bad_div
         $error("nib_serial_master: DIV_W must be within 1..16");
      end
   endgenerate

   logic             accept;
   logic             phase_end;
   logic             is_read;
   logic [IDX_W-1:0] bit_idx;
   logic             sample;
   logic             advance;
   logic [DIV_W-1:0] half_q;

   assign accept = req_start && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         half_q <= '0;
      else if (accept)
         half_q <= cfg_half;
   end

   nsm_tick #(.DIV_W(DIV_W)) u_tick (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (busy),
      .half      (half_q),
      .phase_end (phase_end)
   );

   nsm_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .req_read  (req_read),
      .phase_end (phase_end),
      .busy      (busy),
      .sclk      (sclk),
      .is_read   (is_read),
      .bit_idx   (bit_idx),
      .sample    (sample),
      .advance   (advance),
      .done      (done),
      .oe        (sdo_oe)
   );

   nsm_shifter #(.HOLD_RDATA(HOLD_RDATA)) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .accept    (accept),
      .req_read  (req_read),
      .req_addr  (req_addr),
      .req_wdata (req_wdata),
      .advance   (advance),
      .sample    (sample),
      .is_read   (is_read),
      .bit_idx   (bit_idx),
      .done      (done),
      .sdi       (sdi),
      .sdo       (sdo),
      .rdata     (rdata)
   );
endmodule

// File: rtl/nsm_chk.sv
module nsm_chk #(
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_start,
   input logic             req_read,
   input logic             busy,
   input logic             done,
   input logic [3:0]       rdata,
   input logic             sclk,
   input logic             sdo_oe,
   input logic [DIV_W-1:0] cfg_half
);
   logic rd_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         rd_q <= 1'b0;
      else if (req_start && !busy)
         rd_q <= req_read;
   end

   // R8
   done_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R9
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!sclk && sdo_oe && !busy));

   // R7
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req_start));

   // R9
   sclk_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk);

   // R3
   wr_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !rd_q) |-> sdo_oe);

   // R8
   wr_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !rd_q) |-> (rdata == 4'h0));
endmodule

bind nib_serial_master nsm_chk #(.DIV_W(DIV_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .req_start (req_start),
   .req_read  (req_read),
   .busy      (busy),
   .done      (done),
   .rdata     (rdata),
   .sclk      (sclk),
   .sdo_oe    (sdo_oe),
   .cfg_half  (cfg_half)
);

// File: tb/nib_serial_master_test.sv
module nib_serial_master_test;
   localparam int PERIOD = 10;
   localparam int DIV_W  = 8;
   localparam int NVEC   = 6;
   // {read, addr, wdata, slave pattern (dummy nibble, data nibble), half}
   localparam logic [19:0] VEC [0:NVEC-1] = '{
      {1'b1, 4'hA, 4'h0, 8'h5C, 3'd0},
      {1'b1, 4'h3, 4'h0, 8'hA6, 3'd2},
      {1'b0, 4'h5, 4'h9, 8'h00, 3'd1},
      {1'b0, 4'hF, 4'h0, 8'hFF, 3'd0},
      {1'b1, 4'h0, 4'h0, 8'hF0, 3'd3},
      {1'b0, 4'h8, 4'hF, 8'h00, 3'd4}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_start = 1'b0;
   logic req_read = 1'b0;
   logic [3:0] req_addr = '0;
   logic [3:0] req_wdata = '0;
   logic [DIV_W-1:0] cfg_half = '0;
   logic busy, done, sclk, sdo, sdo_oe, sdi;
   logic [3:0] rdata;

   int tests = 0;
   int fails = 0;

   logic [15:0] pat16 = '0;
   logic        mon_clr = 1'b0;
   int          nrise;
   logic [15:0] got_bits, got_oe;

   always #(PERIOD/2) clk = ~clk;

   nib_serial_master #(.DIV_W(DIV_W)) uut (
      .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_read(req_read),
      .req_addr(req_addr), .req_wdata(req_wdata), .cfg_half(cfg_half),
      .busy(busy), .done(done), .rdata(rdata), .sclk(sclk), .sdo(sdo),
      .sdo_oe(sdo_oe), .sdi(sdi)
   );

   // slave model: one input bit per slot, selected by the number of rises so far
   assign sdi = (nrise < 16) ? pat16[15 - nrise] : 1'b0;

   always @(posedge sclk or posedge mon_clr) begin
      if (mon_clr) begin
         nrise    <= 0;
         got_bits <= '0;
         got_oe   <= '0;
      end else begin
         nrise    <= nrise + 1;
         got_bits <= {got_bits[14:0], sdo};
         got_oe   <= {got_oe[14:0], sdo_oe};
      end
   end

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic run_txn(input logic rd, input logic [3:0] addr, input logic [3:0] wd,
                          input logic [7:0] pat, input int half, input bit glitch);
      int n = 0;
      int first_rise = 0;
      logic [3:0] rd_at_done = '0;
      @(negedge clk);
      mon_clr = 1'b1;
      pat16 = {8'h00, pat};
      @(negedge clk);
      mon_clr = 1'b0;
      req_read = rd; req_addr = addr; req_wdata = wd;
      cfg_half = DIV_W'(half);
      req_start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      req_start = 1'b0;
      check("R7 busy after accept", 32'(busy), 32'd1);
      while (n < 4000) begin
         @(posedge clk);
         n++;
         @(negedge clk);
         if (glitch) begin
            req_start = (n == 5);
            req_read = ~rd; req_addr = ~addr; req_wdata = ~wd;
            cfg_half = '0;
         end
         if (sclk && first_rise == 0) first_rise = n;
         if (done) begin
            rd_at_done = rdata;
            break;
         end
         if (!busy) break;
      end
      req_start = 1'b0;
      check("R6 first rise cycles", 32'(first_rise), 32'(half + 1));
      check("R6 done cycles", 32'(n), 32'(32 * (half + 1)));
      check("R9 idle at done", {29'd0, sclk, sdo_oe, busy}, 32'b010);
      if (rd) begin
         check("R2 read frame", 32'(got_bits[15:8]), {24'd0, 4'b1110, addr});
         check("R3 read oe", 32'(got_oe), 32'h0000FF00);
         check("R4 read nibble", 32'(rd_at_done), 32'(pat[3:0]));
      end else begin
         check("R5 write frame", 32'(got_bits), {16'd0, 4'b1010, addr, 4'b1001, wd});
         check("R3 write oe", 32'(got_oe), 32'h0000FFFF);
         check("R8 write rdata zero", 32'(rd_at_done), 32'd0);
      end
      @(negedge clk);
      check("R8 done one cycle", 32'(done), 32'd0);
   endtask

   initial begin
      #(PERIOD * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      mon_clr = 1'b1;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 sclk low", 32'(sclk), 32'd0);
      check("R1 oe high", 32'(sdo_oe), 32'd1);
      check("R1 busy low", 32'(busy), 32'd0);
      check("R1 done low", 32'(done), 32'd0);
      rst_n = 1'b1;
      mon_clr = 1'b0;
      repeat (2) @(negedge clk);

      for (int i = 0; i < NVEC; i++)
         run_txn(VEC[i][19], VEC[i][18:15], VEC[i][14:11], VEC[i][10:3],
                 int'(VEC[i][2:0]), 1'b0);

      // R7: request during a read is ignored; dummy bits differ from data (R4)
      run_txn(1'b1, 4'h6, 4'h0, 8'h3A, 1, 1'b1);
      begin
         int rises = 0;
         for (int k = 0; k < 60; k++) begin
            @(negedge clk);
            if (sclk || busy) rises++;
         end
         check("R7 no frame after ignored start", 32'(rises), 32'd0);
      end

      // R7 and R5: request during a write is ignored
      run_txn(1'b0, 4'hC, 4'h3, 8'h00, 2, 1'b1);

      // R9: clock remains low while idle
      repeat (10) @(negedge clk);
      check("R9 idle sclk", 32'(sclk), 32'd0);

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule